// File: doc/BRIEF.md
# Inclusive Outer-Cache Snoop Filter

This block is the tag and coherence-state directory of a shared outer cache that stays inclusive of the private inner caches of several cores. Every line held by any core has a matching outer tag. Each entry carries one presence bit per core and an owned flag. The owned flag marks that the single present core holds the line exclusive or modified, so the outer data may be stale. Because of inclusion, the tags also serve as a snoop filter. A tag miss proves that no core holds the line, so no message is sent to any core. A hit names the exact cores to invalidate, or the single owner that must supply the data.

Cores send reads, read-for-ownership requests and eviction notices. The block answers each request with a response that says which kind of grant was given and where the data comes from. It drives per-core snoop lines and collects per-core acknowledgements, each of which may carry dirty data. When an allocation displaces a line, the block back-invalidates that line in every core that holds it. When the displaced line's outer data is newer than memory, the block raises a one-cycle writeback notice. The data array and the memory side are outside this block.

Top module: `snoop_filter`

## Requirements
- R1: A request is taken on `req_valid && req_ready`. Only one request is in flight at a time. `req_ready` is low from the cycle after acceptance until the cycle after `rsp_valid`. Op codes: 0 read, 1 read-for-ownership, 2 clean eviction notice, 3 dirty eviction notice.
- R2: A read or read-for-ownership whose address misses the tags sends no snoop to any core for that address. It allocates the line owned by the requester and responds with `rsp_src`=1 (memory) and `rsp_excl`=1. Source codes: 0 outer array, 1 memory, 2 owning core.
- R3: A read that hits a line owned by another core sends one snoop with `snp_inv`=0, to that owner only. It responds with `rsp_src`=2 and `rsp_excl`=0, and both cores are left as sharers.
- R4: A read that hits a line not owned by another core sends no snoop and responds with `rsp_src`=0. `rsp_excl` is 1 exactly when no other core holds the line, and in that case the requester becomes owner.
- R5: A read-for-ownership that hits sends `snp_inv`=1 to exactly the other holders. It responds only after every one of them has acknowledged, with `rsp_excl`=1. The source is 2 if another core owned the line, else 0.
- R6: A dirty eviction notice, or a dirty acknowledgement, marks the outer data as modified. A later read is then served from the outer array, and displacing that line raises `wb_valid` with its address.
- R7: An eviction notice clears the sender's presence bit, so later requests never snoop that core for the line. A notice for an address not in the tags changes nothing and sends no snoop.
- R8: An allocation uses the lowest-numbered invalid way of the set (set = low address bits). Otherwise it uses the least recently used of the 4 ways, where reads and read-for-ownership requests count as uses and eviction notices do not.
- R9: Before a displaced line is reused, `snp_inv`=1 is sent at the displaced line's address to every core that holds it. The response waits for all of their acknowledgements.
- R10: `wb_valid` is high only in the response cycle of an allocation whose displaced line was modified, either before the request or by a dirty acknowledgement during its back-invalidation. `wb_addr` gives that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_core | input | CW | Requesting core |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | AW | Line address, low bits select the set |
| snp_valid | output | NC | Per-core snoop outstanding |
| snp_inv | output | 1 | 1 = invalidate, 0 = supply data and keep shared |
| snp_addr | output | AW | Line address of the snoop |
| snp_ack | input | NC | Per-core snoop acknowledgement pulse |
| snp_ack_dirty | input | NC | With the ack: the core returned modified data |
| rsp_valid | output | 1 | One-cycle response |
| rsp_core | output | CW | Core the response is for |
| rsp_excl | output | 1 | Exclusive ownership granted |
| rsp_src | output | 2 | Data source (see R2) |
| wb_valid | output | 1 | Displaced modified line must be written to memory |
| wb_addr | output | AW | Address of that line |

## Verification
The back-invalidation of a displaced line and the fill response for the new line finish in the same cycle. That cycle raises both `rsp_valid` and, when the victim was modified, `wb_valid`. A directed sequence makes a dirty-written line the least recently used entry of a full set while another core still owns it. A fresh address in that set then forces the invalidate, the allocation and the writeback together. The bench judges the snoop address, the set of cores invalidated, the response source and the writeback address in that single response cycle. Random traffic over six tags per set also repeats the collision, and dirty acknowledgements arrive mid-invalidation.

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int NC   = 4,
  parameter int SETS = 4,
  parameter int AW   = 16,
  localparam int CW  = $clog2(NC),
  localparam int SW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_core,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic [NC-1:0] snp_valid,
  output logic          snp_inv,
  output logic [AW-1:0] snp_addr,
  input  logic [NC-1:0] snp_ack,
  input  logic [NC-1:0] snp_ack_dirty,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_core,
  output logic          rsp_excl,
  output logic [1:0]    rsp_src,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr
);
  localparam int WAYS = 4;
  localparam int TW   = AW - SW;
  localparam int N    = SETS * WAYS;
  localparam int IW   = SW + 2;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_RFO = 2'd1;
  localparam logic [1:0] OP_EVD = 2'd3;
  localparam logic [1:0] SRC_OUT = 2'd0;
  localparam logic [1:0] SRC_MEM = 2'd1;
  localparam logic [1:0] SRC_OWN = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT, S_DONE} st_t;
  st_t st;

  logic          e_v   [N];
  logic [TW-1:0] e_tag [N];
  logic [NC-1:0] e_pres[N];
  logic          e_own [N];
  logic          e_dty [N];
  logic [1:0]    e_age [N];

  logic [CW-1:0] core_q;
  logic [1:0]    op_q, way_q, src_q;
  logic [AW-1:0] addr_q, saddr_q;
  logic [NC-1:0] pend;
  logic          hit_q, alloc_q, excl_q, inv_q, adty;

  function automatic logic [IW-1:0] ix(input logic [SW-1:0] s, input int w);
    return {s, 2'(w)};
  endfunction

  wire [SW-1:0] set_s = addr_q[SW-1:0];
  wire [TW-1:0] tag_s = addr_q[AW-1:SW];
  wire [NC-1:0] cbit  = NC'(1) << core_q;
  wire          rdish = (op_q == OP_RD) || (op_q == OP_RFO);

  logic       hit, vfound;
  logic [1:0] hway, vway;
  always_comb begin
    hit = 1'b0; hway = 2'd0; vfound = 1'b0; vway = 2'd0;
    for (int w = 0; w < WAYS; w++)
      if (e_v[ix(set_s, w)] && e_tag[ix(set_s, w)] == tag_s) begin
        hit = 1'b1; hway = 2'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (!vfound && !e_v[ix(set_s, w)]) begin
        vfound = 1'b1; vway = 2'(w);
      end
    if (!vfound)
      for (int w = 0; w < WAYS; w++)
        if (e_age[ix(set_s, w)] == 2'd3) vway = 2'(w);
  end

  wire [1:0]    cw      = (st == S_LOOK) ? (hit ? hway : vway) : way_q;
  wire [IW-1:0] ci      = {set_s, cw};
  wire [NC-1:0] p_sel   = e_pres[ci];
  wire          own_sel = e_own[ci];
  wire [NC-1:0] others  = p_sel & ~cbit;
  wire          alloc_n = !hit && rdish;

  logic [NC-1:0] tgt;
  always_comb begin
    tgt = '0;
    if (alloc_n)                                 tgt = e_v[ci] ? p_sel : '0;
    else if (hit && op_q == OP_RFO)              tgt = others;
    else if (hit && op_q == OP_RD && own_sel)    tgt = others;
  end

  wire       excl_n = alloc_n || (hit && op_q == OP_RFO) ||
                      (hit && op_q == OP_RD && others == '0);
  wire [1:0] src_n  = alloc_n ? SRC_MEM :
                      (hit && rdish && own_sel && others != '0) ? SRC_OWN : SRC_OUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; core_q <= '0; op_q <= '0; addr_q <= '0; way_q <= '0;
      hit_q <= 1'b0; alloc_q <= 1'b0; excl_q <= 1'b0; src_q <= '0;
      inv_q <= 1'b0; saddr_q <= '0; pend <= '0; adty <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          core_q <= req_core; op_q <= req_op; addr_q <= req_addr; st <= S_LOOK;
        end
        S_LOOK: begin
          way_q   <= cw;
          hit_q   <= hit;
          alloc_q <= alloc_n;
          excl_q  <= excl_n;
          src_q   <= src_n;
          adty    <= 1'b0;
          inv_q   <= !(hit && op_q == OP_RD);
          saddr_q <= alloc_n ? {e_tag[ci], set_s} : addr_q;
          pend    <= tgt;
          st      <= (tgt != '0) ? S_WAIT : S_DONE;
        end
        S_WAIT: begin
          pend <= pend & ~snp_ack;
          if (|(pend & snp_ack & snp_ack_dirty)) adty <= 1'b1;
          if ((pend & ~snp_ack) == '0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_v[i] <= 1'b0; e_tag[i] <= '0; e_pres[i] <= '0;
        e_own[i] <= 1'b0; e_dty[i] <= 1'b0; e_age[i] <= 2'(i);
      end
    end else if (st == S_DONE) begin
      if (alloc_q) begin
        e_v[ci] <= 1'b1; e_tag[ci] <= tag_s; e_pres[ci] <= cbit;
        e_own[ci] <= 1'b1; e_dty[ci] <= 1'b0;
      end else if (hit_q) begin
        case (op_q)
          OP_RD: begin
            e_pres[ci] <= p_sel | cbit; e_own[ci] <= excl_q; e_dty[ci] <= e_dty[ci] | adty;
          end
          OP_RFO: begin
            e_pres[ci] <= cbit; e_own[ci] <= 1'b1; e_dty[ci] <= e_dty[ci] | adty;
          end
          default: begin
            e_pres[ci] <= others;
            e_own[ci]  <= own_sel && (others != '0);
            if (op_q == OP_EVD) e_dty[ci] <= 1'b1;
          end
        endcase
      end
      if (rdish)
        for (int w = 0; w < WAYS; w++) begin
          if (2'(w) == way_q)                      e_age[ix(set_s, w)] <= 2'd0;
          else if (e_age[ix(set_s, w)] < e_age[ci]) e_age[ix(set_s, w)] <= e_age[ix(set_s, w)] + 2'd1;
        end
    end
  end

  assign req_ready = (st == S_IDLE);
  assign snp_valid = (st == S_WAIT) ? pend : '0;
  assign snp_inv   = inv_q;
  assign snp_addr  = saddr_q;
  assign rsp_valid = (st == S_DONE);
  assign rsp_core  = core_q;
  assign rsp_excl  = excl_q;
  assign rsp_src   = src_q;
  assign wb_valid  = (st == S_DONE) && alloc_q && e_v[ci] && (e_dty[ci] || adty);
  assign wb_addr   = {e_tag[ci], set_s};

  // R1
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R1
  ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  // R5
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (snp_valid == '0));
  // R5
  pend_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0 && $past(snp_valid) != '0) |-> ((snp_valid & ~$past(snp_valid)) == '0));
  // R3
  fwd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0 && !snp_inv) |-> ($countones(snp_valid) == 1));
  // R5
  no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0 && !alloc_q) |-> ((snp_valid & cbit) == '0));
  // R10
  wb_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && rsp_src == SRC_MEM));

  for (genvar g = 0; g < N; g++) begin : g_inv
    // R9
    owner_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_own[g] |-> ($countones(e_pres[g]) == 1));
    // R9
    inclusion_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_pres[g] != '0) |-> e_v[g]);
  end
endmodule

// File: tb/snoop_filter_bench.sv
`timescale 1ns/1ps
module snoop_filter_bench;
  localparam int NC = 4, SETS = 4, AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_core = '0, req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [NC-1:0] snp_valid, snp_ack = '0, snp_ack_dirty = '0;
  logic snp_inv, rsp_valid, rsp_excl, wb_valid;
  logic [AW-1:0] snp_addr, wb_addr;
  logic [1:0] rsp_core, rsp_src;

  always #2 clk = ~clk;

  snoop_filter #(.NC(NC), .SETS(SETS), .AW(AW)) u_snoop_filter (.*);

  int nchk = 0, nerr = 0, tick = 0;
  bit m_v [SETS][4]; int m_tag [SETS][4]; logic [3:0] m_pres [SETS][4];
  bit m_own [SETS][4]; bit m_dty [SETS][4]; int m_ts [SETS][4];
  int last_seen, last_src, last_wb, last_wba, last_snpa;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s: actual %0d expected %0d", r, act, exp); end
  endtask

  task automatic run(input int c, input int op, input int a);
    int s = a % SETS, t = a / SETS, hw = -1, vw = -1, e, cyc = 0;
    logic [3:0] cb = 4'(1 << c), oth, tgt = '0, omask, seen = '0;
    bit alloc, einv, eexcl, dacc = 0, ewb, firsts = 1;
    int esrc, esa;
    string lb;
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_tag[s][w] == t) hw = w;
    for (int w = 0; w < 4; w++) if (vw < 0 && !m_v[s][w]) vw = w;
    if (vw < 0) begin
      vw = 0;
      for (int w = 1; w < 4; w++) if (m_ts[s][w] < m_ts[s][vw]) vw = w;
    end
    e = (hw >= 0) ? hw : vw;
    alloc = (hw < 0) && (op < 2);
    oth = m_pres[s][e] & ~cb;
    omask = m_own[s][e] ? m_pres[s][e] : '0;
    if (alloc) tgt = m_v[s][e] ? m_pres[s][e] : '0;
    else if (hw >= 0 && op == 1) tgt = oth;
    else if (hw >= 0 && op == 0 && m_own[s][e]) tgt = oth;
    einv = !(hw >= 0 && op == 0);
    eexcl = alloc || (hw >= 0 && op == 1) || (hw >= 0 && op == 0 && oth == 0);
    esrc = alloc ? 1 : (hw >= 0 && op < 2 && m_own[s][e] && oth != 0) ? 2 : 0;
    esa = alloc ? (m_tag[s][e] * SETS + s) : a;
    if (alloc) lb = (tgt != 0) ? "R9" : "R2";
    else if (hw >= 0 && op == 0) lb = (tgt != 0) ? "R3" : "R4";
    else if (hw >= 0 && op == 1) lb = "R5";
    else lb = "R7";

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    req_valid = 1'b1; req_core = 2'(c); req_op = 2'(op); req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", req_ready, 0);
    while (!rsp_valid && cyc < 500) begin
      if (snp_valid != 0) begin
        if (firsts) begin
          chk(snp_inv == einv, lb, snp_inv, einv);
          chk(snp_addr == AW'(esa), alloc ? "R8" : lb, snp_addr, esa);
          firsts = 0;
        end
        seen |= snp_valid;
      end
      snp_ack = snp_valid & 4'($urandom);
      snp_ack_dirty = snp_ack & omask & 4'($urandom);
      if (snp_ack_dirty != 0) dacc = 1;
      @(negedge clk); cyc++;
    end
    snp_ack = '0; snp_ack_dirty = '0;
    if (cyc >= 500) chk(0, "R1", cyc, 0);
    ewb = alloc && m_v[s][e] && (m_dty[s][e] || dacc);
    chk(seen == tgt, lb, seen, tgt);
    chk(rsp_core == 2'(c), "R1", rsp_core, c);
    chk(rsp_src == 2'(esrc), lb, rsp_src, esrc);
    chk(rsp_excl == eexcl, lb, rsp_excl, eexcl);
    chk(wb_valid == ewb, "R10", wb_valid, ewb);
    if (ewb) chk(wb_addr == AW'(esa), "R10", wb_addr, esa);
    last_seen = seen; last_src = rsp_src; last_wb = wb_valid; last_wba = wb_addr;
    last_snpa = firsts ? -1 : esa;
    if (alloc) begin
      m_v[s][e] = 1; m_tag[s][e] = t; m_pres[s][e] = cb; m_own[s][e] = 1; m_dty[s][e] = 0;
    end else if (hw >= 0) begin
      if (op == 0) begin
        m_pres[s][e] |= cb; m_own[s][e] = eexcl; m_dty[s][e] |= dacc;
      end else if (op == 1) begin
        m_pres[s][e] = cb; m_own[s][e] = 1; m_dty[s][e] |= dacc;
      end else begin
        m_own[s][e] = m_own[s][e] && (oth != 0);
        m_pres[s][e] = oth;
        if (op == 3) m_dty[s][e] = 1;
      end
    end
    if (op < 2) m_ts[s][e] = ++tick;
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "R1", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = 0; m_pres[s][w] = 0;
        m_own[s][w] = 0; m_dty[s][w] = 0; m_ts[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(snp_valid == 0 && rsp_valid == 0 && wb_valid == 0, "R1", snp_valid, 0);

    run(0, 0, 5);  chk(last_src == 1 && last_seen == 0, "R2", last_src, 1);
    run(1, 0, 5);  chk(last_seen == 1, "R3", last_seen, 1);
    run(2, 0, 5);  chk(last_seen == 0 && last_src == 0, "R4", last_seen, 0);
    run(3, 1, 5);  chk(last_seen == 7, "R5", last_seen, 7);
    run(3, 3, 5);
    run(0, 0, 5);  chk(last_src == 0 && last_seen == 0, "R6", last_src, 0);
    run(0, 2, 5);
    run(1, 1, 5);  chk(last_seen == 0, "R7", last_seen, 0);
    run(2, 2, 61); chk(last_seen == 0, "R7", last_seen, 0);
    run(2, 0, 9);
    run(2, 0, 13);
    run(2, 0, 17);
    run(2, 0, 21);
    chk(last_snpa == 5 && last_seen == 2, "R8", last_snpa, 5);
    chk(last_wb == 1 && last_wba == 5, "R6", last_wba, 5);
    run(3, 0, 9);
    run(0, 0, 25); chk(last_snpa == 13, "R8", last_snpa, 13);

    for (int i = 0; i < 900; i++)
      run(int'($urandom % 4), int'($urandom % 4), int'(($urandom % 6) * SETS + $urandom % SETS));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule